// File: doc/BRIEF.md
# Register-Offset Load/Store Address and Extension Unit

This unit sits between a register file and a 32-bit little-endian data memory port. It serves load and store operations whose address is a base register plus a second register used as an index. For each request it adds the base value to the index value shifted left by zero to three bits. For stores it places the data into the addressed byte lanes and raises the matching byte enables. It also checks whether the register indices are legal for the requested access size and direction, and whether the address is aligned.

Request results are registered and appear one cycle after `req_valid`. A `acc_done` pulse reports every request, together with its illegal and misaligned flags. The memory request is raised only for an access that is both legal and aligned. Load data arrives with `mem_rvalid` and is registered one cycle later on `ld_data`. Before that, it is sign- or zero-extended according to the access type that was captured when the load was issued. `ld_idx` carries the destination register index.

Top module: `lsx_unit`

## Requirements
- R1: `mem_addr` equals `base_val + (ofs_val << shamt)` modulo 2^32 and is valid in the cycle after `req_valid`, when `mem_req` is 1. `mem_we` equals `req_store`.
- R2: Access type codes are 0 unsigned byte, 1 signed byte, 2 unsigned halfword, 3 signed halfword and 4 word. For a store, a byte access gives `mem_be = 1 << addr[1:0]` with the low byte of `st_data` copied to all four lanes. A halfword access gives `mem_be` 4'b0011 when `addr[1]` is 0 and 4'b1100 otherwise, with the low half copied to both halves. A word access gives 4'b1111 with `st_data` unchanged.
- R3: For a load, a byte is taken from bits `8*addr[1:0]` and a halfword from the half chosen by `addr[1]`. Types 0 and 2 zero-extend the value to 32 bits, types 1 and 3 sign-extend it, and type 4 returns the whole word.
- R4: A store of type 1 or 3 sets `acc_illegal`.
- R5: A base index of 15 (the program counter) sets `acc_illegal`.
- R6: An offset index of 13 (the stack pointer) or 15 sets `acc_illegal`.
- R7: A transfer index of 13 is legal only for type 4. A transfer index of 15 is legal only for a type-4 load. Any other use of either index sets `acc_illegal`.
- R8: `acc_misalign` is 1 for a halfword access with `addr[0]` set, or for a word access with `addr[1:0]` nonzero. Byte accesses are never misaligned.
- R9: `acc_done` pulses for exactly one cycle, one cycle after each request. `mem_req` is 1 in that cycle only when both `acc_illegal` and `acc_misalign` are 0.
- R10: After reset, every output is 0.
- R11: Type codes 5, 6 and 7 set `acc_illegal`.
- R12: `ld_valid` is 1 in the cycle after `mem_rvalid`. In that cycle `ld_idx` holds the transfer index of the last load that was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_type | input | 3 | Access type code |
| base_val | input | 32 | Base register value |
| base_idx | input | 4 | Base register index |
| ofs_val | input | 32 | Offset register value |
| ofs_idx | input | 4 | Offset register index |
| shamt | input | 2 | Left shift applied to the offset |
| xfer_idx | input | 4 | Transfer register index |
| st_data | input | 32 | Store data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Effective address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rvalid | input | 1 | Read data valid from memory |
| mem_rdata | input | 32 | Read data from memory |
| acc_done | output | 1 | Request completion pulse |
| acc_illegal | output | 1 | Illegal register or type combination |
| acc_misalign | output | 1 | Misaligned address |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| ld_idx | output | 4 | Destination register index of the load |

## Verification
The hardest cases to reach are the combinations where several restrictions could apply at once. Examples are the program counter used as the transfer register for a word load, which is the single legal use, or the stack pointer used for a word store. These cases separate a per-field check from a proper per-direction check, but uniform random indices reach them only rarely. The bench therefore steers one draw in four onto indices 13 and 15, and it forces the low bits of the summed address to be aligned half of the time. This ensures that legal sub-word loads in every lane are reached and their extension is checked, instead of most requests ending as misaligned.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
    localparam int DW     = 32;
    localparam int RIDX_W = 4;
    localparam int NLANE  = DW / 8;
    localparam int LANE_W = $clog2(NLANE);
    localparam logic [RIDX_W-1:0] SP_IDX = 4'd13;
    localparam logic [RIDX_W-1:0] PC_IDX = 4'd15;

    typedef enum logic [2:0] {
        ACC_UB = 3'd0,
        ACC_SB = 3'd1,
        ACC_UH = 3'd2,
        ACC_SH = 3'd3,
        ACC_W  = 3'd4
    } acc_t;

    typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W} size_t;

    function automatic size_t size_of(input logic [2:0] t);
        case (t)
            ACC_UH, ACC_SH: return SZ_H;
            ACC_W:          return SZ_W;
            default:        return SZ_B;
        endcase
    endfunction

    typedef struct packed {
        logic              mem_req;
        logic              mem_we;
        logic [DW-1:0]     addr;
        logic [NLANE-1:0]  be;
        logic [DW-1:0]     wdata;
        logic              done;
        logic              ill;
        logic              mis;
        logic              ld_valid;
        logic [DW-1:0]     ld_data;
        logic [RIDX_W-1:0] ld_idx;
        logic [2:0]        pend_type;
        logic [LANE_W-1:0] pend_lo;
        logic [RIDX_W-1:0] pend_idx;
    } state_t;
endpackage

// File: rtl/lsx_agen.sv
module lsx_agen
    import lsx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0]       base_val,
    input  logic [W-1:0]       ofs_val,
    input  logic [1:0]         shamt,
    input  logic [2:0]         acc_type,
    input  logic [W-1:0]       st_data,
    output logic [W-1:0]       addr,
    output logic               misalign,
    output logic [W/8-1:0]     be,
    output logic [W-1:0]       wdata
);
    localparam int NL = W / 8;
    localparam int LW = $clog2(NL);

    size_t sz;

    always_comb begin
        addr = base_val + (ofs_val << shamt);
        sz   = size_of(acc_type);
        misalign = 1'b0;
        be       = '0;
        wdata    = '0;
        case (sz)
            SZ_B: begin
                be = NL'(1) << addr[LW-1:0];
                for (int i = 0; i < NL; i++) wdata[i*8 +: 8] = st_data[7:0];
            end
            SZ_H: begin
                misalign = addr[0];
                be = addr[1] ? NL'(4'b1100) : NL'(4'b0011);
                for (int i = 0; i < NL/2; i++) wdata[i*16 +: 16] = st_data[15:0];
            end
            default: begin
                misalign = |addr[LW-1:0];
                be = '1;
                wdata = st_data;
            end
        endcase
    end
endmodule

// File: rtl/lsx_legal.sv
module lsx_legal
    import lsx_pkg::*;
#(
    parameter int IW = RIDX_W
) (
    input  logic          is_store,
    input  logic [2:0]    acc_type,
    input  logic [IW-1:0] base_idx,
    input  logic [IW-1:0] ofs_idx,
    input  logic [IW-1:0] xfer_idx,
    output logic          illegal
);
    logic bad_type, bad_base, bad_ofs, bad_xfer, is_word;

    always_comb begin
        is_word  = (acc_type == ACC_W);
        bad_type = (acc_type > ACC_W) ||
                   (is_store && (acc_type == ACC_SB || acc_type == ACC_SH));
        bad_base = (base_idx == PC_IDX);
        bad_ofs  = (ofs_idx == SP_IDX) || (ofs_idx == PC_IDX);
        bad_xfer = ((xfer_idx == SP_IDX) && !is_word) ||
                   ((xfer_idx == PC_IDX) && (!is_word || is_store));
        illegal  = bad_type || bad_base || bad_ofs || bad_xfer;
    end
endmodule

// File: rtl/lsx_extend.sv
module lsx_extend
    import lsx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [2:0]              acc_type,
    input  logic [$clog2(W/8)-1:0]  lo,
    input  logic [W-1:0]            word,
    output logic [W-1:0]            result
);
    logic [7:0]  b;
    logic [15:0] h;

    always_comb begin
        b = 8'(word >> {lo, 3'b000});
        h = lo[1] ? word[31:16] : word[15:0];
        case (acc_type)
            ACC_UB:  result = {{(W-8){1'b0}}, b};
            ACC_SB:  result = {{(W-8){b[7]}}, b};
            ACC_UH:  result = {{(W-16){1'b0}}, h};
            ACC_SH:  result = {{(W-16){h[15]}}, h};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lsx_unit.sv
module lsx_unit
    import lsx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [2:0]        req_type,
    input  logic [31:0]       base_val,
    input  logic [3:0]        base_idx,
    input  logic [31:0]       ofs_val,
    input  logic [3:0]        ofs_idx,
    input  logic [1:0]        shamt,
    input  logic [3:0]        xfer_idx,
    input  logic [31:0]       st_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              acc_done,
    output logic              acc_illegal,
    output logic              acc_misalign,
    output logic              ld_valid,
    output logic [31:0]       ld_data,
    output logic [3:0]        ld_idx
);
    state_t s_d, s_q;

    logic [DW-1:0]    ag_addr, ag_wdata, ext_res;
    logic [NLANE-1:0] ag_be;
    logic             ag_mis, lg_ill;

    lsx_agen #(.W(DW)) u_agen (
        .base_val(base_val), .ofs_val(ofs_val), .shamt(shamt),
        .acc_type(req_type), .st_data(st_data),
        .addr(ag_addr), .misalign(ag_mis), .be(ag_be), .wdata(ag_wdata)
    );

    lsx_legal #(.IW(RIDX_W)) u_legal (
        .is_store(req_store), .acc_type(req_type), .base_idx(base_idx),
        .ofs_idx(ofs_idx), .xfer_idx(xfer_idx), .illegal(lg_ill)
    );

    lsx_extend #(.W(DW)) u_ext (
        .acc_type(s_q.pend_type), .lo(s_q.pend_lo), .word(mem_rdata),
        .result(ext_res)
    );

    always_comb begin
        s_d          = s_q;
        s_d.done     = req_valid;
        s_d.mem_req  = req_valid && !lg_ill && !ag_mis;
        s_d.ld_valid = mem_rvalid;
        if (req_valid) begin
            s_d.ill   = lg_ill;
            s_d.mis   = ag_mis;
            s_d.addr  = ag_addr;
            s_d.mem_we = req_store;
            s_d.be    = req_store ? ag_be : '0;
            s_d.wdata = req_store ? ag_wdata : '0;
            if (!req_store && !lg_ill && !ag_mis) begin
                s_d.pend_type = req_type;
                s_d.pend_lo   = ag_addr[LANE_W-1:0];
                s_d.pend_idx  = xfer_idx;
            end
        end
        if (mem_rvalid) begin
            s_d.ld_data = ext_res;
            s_d.ld_idx  = s_q.pend_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_req      = s_q.mem_req;
    assign mem_we       = s_q.mem_we;
    assign mem_addr     = s_q.addr;
    assign mem_be       = s_q.be;
    assign mem_wdata    = s_q.wdata;
    assign acc_done     = s_q.done;
    assign acc_illegal  = s_q.ill;
    assign acc_misalign = s_q.mis;
    assign ld_valid     = s_q.ld_valid;
    assign ld_data      = s_q.ld_data;
    assign ld_idx       = s_q.ld_idx;

    assert_no_req_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (acc_done && !acc_illegal && !acc_misalign));
    assert_done_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> acc_done);
    assert_be_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be inside {4'b0001, 4'b0010, 4'b0100,
                                  4'b1000, 4'b0011, 4'b1100, 4'b1111}));
    assert_word_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be == 4'b1111) |-> (mem_addr[1:0] == 2'b00));
    assert_ld_after_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |=> ld_valid);
endmodule

// File: tb/lsx_unit_tb.sv
module lsx_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_store = 0;
    logic [2:0] req_type = 0;
    logic [31:0] base_val = 0, ofs_val = 0, st_data = 0, mem_rdata = 0;
    logic [3:0] base_idx = 0, ofs_idx = 0, xfer_idx = 0;
    logic [1:0] shamt = 0;
    logic mem_rvalid = 0;
    logic mem_req, mem_we, acc_done, acc_illegal, acc_misalign, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0] mem_be, ld_idx;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsx_unit u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit e_ill(bit st, logic [2:0] t, logic [3:0] b, logic [3:0] o, logic [3:0] x);
        bit w = (t == 3'd4);
        return (t > 3'd4) || (st && (t == 3'd1 || t == 3'd3)) || b == 4'd15 ||
               o == 4'd13 || o == 4'd15 || (x == 4'd13 && !w) || (x == 4'd15 && (!w || st));
    endfunction

    function automatic bit e_mis(logic [2:0] t, logic [31:0] a);
        if (t == 3'd2 || t == 3'd3) return a[0];
        if (t == 3'd4) return a[1:0] != 0;
        return 0;
    endfunction

    function automatic logic [3:0] e_be(logic [2:0] t, logic [31:0] a);
        if (t == 3'd4) return 4'hF;
        if (t == 3'd2 || t == 3'd3) return a[1] ? 4'hC : 4'h3;
        return 4'h1 << a[1:0];
    endfunction

    function automatic logic [31:0] e_wd(logic [2:0] t, logic [31:0] d);
        if (t == 3'd4) return d;
        if (t == 3'd2 || t == 3'd3) return {d[15:0], d[15:0]};
        return {4{d[7:0]}};
    endfunction

    function automatic logic [31:0] e_ld(logic [2:0] t, logic [1:0] lo, logic [31:0] w);
        logic [7:0] b;
        logic [15:0] h;
        b = w[lo*8 +: 8];
        h = lo[1] ? w[31:16] : w[15:0];
        case (t)
            3'd0: return {24'd0, b};
            3'd1: return {{24{b[7]}}, b};
            3'd2: return {16'd0, h};
            3'd3: return {{16{h[15]}}, h};
            default: return w;
        endcase
    endfunction

    task automatic run_op(input bit st, input logic [2:0] t, input logic [31:0] bv,
                          input logic [3:0] bi, input logic [31:0] ov, input logic [3:0] oi,
                          input logic [1:0] sh, input logic [3:0] xi, input logic [31:0] sd);
        logic [31:0] a, rd;
        bit ill, mis, go;
        a = bv + (ov << sh);
        ill = e_ill(st, t, bi, oi, xi);
        mis = e_mis(t, a);
        go = !ill && !mis;
        @(negedge clk);
        req_valid = 1; req_store = st; req_type = t; base_val = bv; base_idx = bi;
        ofs_val = ov; ofs_idx = oi; shamt = sh; xfer_idx = xi; st_data = sd;
        @(negedge clk);
        req_valid = 0;
        chk("R9 done", {31'd0, acc_done}, 32'd1);
        chk("R4/R5/R6/R7/R11 illegal", {31'd0, acc_illegal}, {31'd0, ill});
        chk("R8 misalign", {31'd0, acc_misalign}, {31'd0, mis});
        chk("R9 mem_req", {31'd0, mem_req}, {31'd0, go});
        if (go) begin
            chk("R1 addr", mem_addr, a);
            chk("R1 we", {31'd0, mem_we}, {31'd0, st});
            if (st) begin
                chk("R2 be", {28'd0, mem_be}, {28'd0, e_be(t, a)});
                chk("R2 wdata", mem_wdata, e_wd(t, sd));
            end else begin
                rd = $urandom;
                mem_rvalid = 1; mem_rdata = rd;
                @(negedge clk);
                mem_rvalid = 0;
                chk("R12 ld_valid", {31'd0, ld_valid}, 32'd1);
                chk("R12 ld_idx", {28'd0, ld_idx}, {28'd0, xi});
                chk("R3 ld_data", ld_data, e_ld(t, a[1:0], rd));
                @(negedge clk);
                chk("R12 ld_valid drop", {31'd0, ld_valid}, 32'd0);
            end
        end
    endtask

    function automatic logic [3:0] pick_idx();
        if ($urandom_range(3) == 0) return $urandom_range(1) ? 4'd13 : 4'd15;
        return 4'($urandom);
    endfunction

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 mem_req", {31'd0, mem_req}, 0);
        chk("R10 done", {31'd0, acc_done}, 0);
        chk("R10 ld_valid", {31'd0, ld_valid}, 0);
        chk("R10 addr", mem_addr, 0);
        chk("R10 ld_data", ld_data, 0);
        rst_n = 1;
        // directed corners
        run_op(0, 3'd4, 32'h100, 1, 32'h4, 2, 0, 15, 0);          // R7 PC word load legal
        run_op(1, 3'd4, 32'h100, 1, 32'h4, 2, 0, 15, 1);          // R7 PC store illegal
        run_op(0, 3'd0, 32'h100, 1, 32'h4, 2, 0, 15, 0);          // R7 PC byte load illegal
        run_op(1, 3'd4, 32'h200, 1, 32'h8, 2, 1, 13, 32'hCAFE_F00D); // R7 SP word store legal
        run_op(0, 3'd2, 32'h200, 1, 32'h8, 2, 1, 13, 0);          // R7 SP half load illegal
        run_op(0, 3'd0, 32'h200, 15, 32'h8, 2, 1, 3, 0);          // R5
        run_op(0, 3'd0, 32'h200, 1, 32'h8, 13, 1, 3, 0);          // R6 SP
        run_op(0, 3'd0, 32'h200, 1, 32'h8, 15, 1, 3, 0);          // R6 PC
        run_op(1, 3'd1, 32'h200, 1, 32'h8, 2, 1, 3, 0);           // R4
        run_op(1, 3'd3, 32'h200, 1, 32'h8, 2, 1, 3, 0);           // R4
        run_op(0, 3'd6, 32'h200, 1, 32'h8, 2, 1, 3, 0);           // R11
        run_op(0, 3'd2, 32'h201, 1, 32'h0, 2, 0, 3, 0);           // R8 half misaligned
        run_op(0, 3'd4, 32'h202, 1, 32'h0, 2, 0, 3, 0);           // R8 word misaligned
        run_op(0, 3'd1, 32'hFFFF_FFF0, 1, 32'h7, 2, 3, 4, 0);     // R1 wrap, shift 3, R3 signed byte
        run_op(0, 3'd3, 32'h0, 1, 32'h1, 2, 1, 5, 0);             // R3 signed upper half
        for (int i = 0; i < 600; i++) begin
            logic [31:0] bv, ov;
            logic [1:0] sh;
            logic [2:0] t;
            bv = $urandom; ov = $urandom; sh = 2'($urandom);
            t = ($urandom_range(7) == 0) ? 3'($urandom_range(7, 5)) : 3'($urandom_range(4));
            if ($urandom_range(1)) bv[1:0] = 2'(0 - (ov << sh));
            run_op(1'($urandom), t, bv, pick_idx(), ov, pick_idx(), sh, pick_idx(), $urandom);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule